// File: doc/BRIEF.md
# Unsigned Multiply-Add Twin-Half Unit

This unit takes three unsigned 64-bit operands A, B and C. It forms A*B + C at full 128-bit precision and returns the sum as two 64-bit words. The low word is the primary result and the high word is the secondary result. When the unit is chained across the limbs of a large integer, the high word serves as the 64-bit carry into the next limb. C is always zero-extended. The largest possible sum is (2^64-1)^2 + (2^64-1) = 2^128 - 2^64, so the result always fits in 128 bits and the unit has no overflow indication.

Each request carries a 6-bit extended-opcode field and a destination index. Only the multiply-add-twin code is executed. Requests with any other code are consumed and discarded. With each result the unit returns two destination indices: the primary index, and the primary index plus one for the secondary word.

The arithmetic is a radix-4 iterative engine that retires two multiplier bits per cycle. It works on one operation at a time. A valid/ready handshake on the input and on the output connects it to its neighbours.

Top module: `muladd_twin_half`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: out_lo equals bits 63:0 of the unsigned 128-bit value A*B + C.
- R3: out_hi equals bits 127:64 of A*B + C, where C is zero-extended and never sign-extended. For example, A=0, B=0, C=all ones gives out_hi = 0.
- R4: out_valid rises 32 clock cycles after the edge that accepts a request.
- R5: in_ready is 0 from the accepting edge until the result has been taken.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_lo, out_hi, out_rd_lo and out_rd_hi stay unchanged.
- R7: A request executes only when in_xop = 6'b110010. Any other code, including the neighbouring 6'b110000, 6'b110001 and 6'b110011, is accepted in one cycle, produces no result, and leaves in_ready at 1.
- R8: out_rd_lo equals the request's in_rd, and out_rd_hi equals in_rd + 1 modulo 2^5 (in_rd = 31 gives 0).
- R9: A = B = C = all ones gives out_hi = all ones and out_lo = 0, with no lost carry.
- R10: After the edge where out_valid and out_ready are both 1, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_xop | input | 6 | Extended-opcode field of the request |
| in_rd | input | 5 | Primary destination index |
| in_a | input | 64 | Multiplicand |
| in_b | input | 64 | Multiplier |
| in_c | input | 64 | Addend, zero-extended |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_lo | output | 64 | Low half of A*B + C |
| out_hi | output | 64 | High half of A*B + C |
| out_rd_lo | output | 5 | Destination index for out_lo |
| out_rd_hi | output | 5 | Destination index for out_hi |

## Verification
The hardest case to reach from the ports is a finished result that is held for a long time under backpressure while the next request already waits on in_valid. In that case the result words, both indices and the blocked input must all stay put. The stimulus creates this by running a stall phase, in which out_ready is high only one cycle in five, while the driver queues the next random request immediately after the previous one is accepted. Carry propagation through the upper limb is driven by directed all-ones operands, and the opcode filter is driven by each neighbouring code placed between real requests.

// File: rtl/mth_pkg.sv
`timescale 1ns/1ps
package mth_pkg;
  localparam logic [5:0] XOP_MADD_TWIN = 6'b110010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } mth_state_e;
endpackage

// File: rtl/mth_xop_match.sv
`timescale 1ns/1ps
module mth_xop_match #(
  parameter int         XW    = 6,
  parameter logic [XW-1:0] MATCH = '0
) (
  input  logic [XW-1:0] xop,
  output logic          hit
);
  always_comb hit = (xop == MATCH);
endmodule

// File: rtl/mth_r4_engine.sv
`timescale 1ns/1ps
module mth_r4_engine #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] acc_q, acc_d;
  logic [PW-1:0] mc_q, mc_d;
  logic [DW-1:0] mp_q, mp_d;
  logic [PW-1:0] addend;
  logic [PW:0]   sum;

  // radix-4 digit select: 0, 1x, 2x or 3x of the shifted multiplicand
  always_comb begin
    case (mp_q[1:0])
      2'd0:    addend = '0;
      2'd1:    addend = mc_q;
      2'd2:    addend = mc_q << 1;
      default: addend = mc_q + (mc_q << 1);
    endcase
    sum = {1'b0, acc_q} + {1'b0, addend};
  end

  always_comb begin
    acc_d = acc_q;
    mc_d  = mc_q;
    mp_d  = mp_q;
    if (load) begin
      acc_d = {{DW{1'b0}}, c};
      mc_d  = {{DW{1'b0}}, a};
      mp_d  = b;
    end else if (step) begin
      acc_d = sum[PW-1:0];
      mc_d  = mc_q << 2;
      mp_d  = mp_q >> 2;
    end
  end

  always_ff @(posedge clk) begin
    if (load || step) begin
      acc_q <= acc_d;
      mc_q  <= mc_d;
      mp_q  <= mp_d;
    end
  end

  assign lo = acc_q[DW-1:0];
  assign hi = acc_q[PW-1:DW];

  // R3 / R9: partial sums never leave the 128-bit range
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !sum[PW]);
endmodule

// File: rtl/mth_sequencer.sv
`timescale 1ns/1ps
module mth_sequencer
  import mth_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic op_ok,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load,
  output logic step
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  mth_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_HOLD);
  assign load      = in_valid && in_ready && op_ok;
  assign step      = (st_q == ST_RUN);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (load) begin
        st_d  = ST_RUN;
        cnt_d = '0;
      end
      ST_RUN: begin
        if (cnt_q == LAST) st_d = ST_HOLD;
        else               cnt_d = cnt_q + 1'b1;
      end
      ST_HOLD: if (out_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  a_r5_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!in_ready && !out_valid));

  a_r7_foreign_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !op_ok) |=> (in_ready && !out_valid));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));
endmodule

// File: rtl/muladd_twin_half.sv
`timescale 1ns/1ps
module muladd_twin_half
  import mth_pkg::*;
#(
  parameter int DW = 64,
  parameter int XW = 6,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_xop,
  input  logic [RW-1:0] in_rd,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_lo,
  output logic [DW-1:0] out_hi,
  output logic [RW-1:0] out_rd_lo,
  output logic [RW-1:0] out_rd_hi
);
  localparam int ITER = DW / 2;

  logic op_ok, load, step;
  logic [RW-1:0] rd_q;

  mth_xop_match #(.XW(XW), .MATCH(XW'(XOP_MADD_TWIN))) u_match (
    .xop (in_xop),
    .hit (op_ok)
  );

  mth_sequencer #(.ITER(ITER)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_ok     (op_ok),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step)
  );

  mth_r4_engine #(.DW(DW)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a     (in_a),
    .b     (in_b),
    .c     (in_c),
    .lo    (out_lo),
    .hi    (out_hi)
  );

  always_ff @(posedge clk) begin
    if (load) rd_q <= in_rd;
  end

  assign out_rd_lo = rd_q;
  assign out_rd_hi = rd_q + RW'(1);

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi)
                                   && $stable(out_rd_lo) && $stable(out_rd_hi)));
endmodule

// File: tb/test_muladd_twin_half.sv
`timescale 1ns/1ps
module test_muladd_twin_half;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_xop = '0;
  logic [4:0]  in_rd = '0;
  logic [63:0] in_a = '0, in_b = '0, in_c = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_lo, out_hi;
  logic [4:0]  out_rd_lo, out_rd_hi;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  int           m_st = 0;
  int           m_cnt = 0;
  logic [127:0] m_exp = '0;
  logic [4:0]   m_rd = '0;
  logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

  localparam logic [63:0] ONES = '1;

  always #2.5 clk = ~clk;

  muladd_twin_half i_muladd_twin_half (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_xop(in_xop), .in_rd(in_rd), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi),
    .out_rd_lo(out_rd_lo), .out_rd_hi(out_rd_hi)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [63:0] next_rng(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  // cycle-by-cycle reference: compare, then predict the next edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_st = 0;
    end else begin
      chk(in_ready == (m_st == 0), "R5", 128'(in_ready), 128'(m_st == 0));
      chk(out_valid == (m_st == 2), "R4 R10", 128'(out_valid), 128'(m_st == 2));
      if (m_st == 2) begin
        chk(out_lo == m_exp[63:0], "R2", 128'(out_lo), 128'(m_exp[63:0]));
        chk(out_hi == m_exp[127:64], "R3 R6", 128'(out_hi), 128'(m_exp[127:64]));
        chk(out_rd_lo == m_rd, "R8", 128'(out_rd_lo), 128'(m_rd));
        chk(out_rd_hi == 5'(m_rd + 5'd1), "R8", 128'(out_rd_hi), 128'(5'(m_rd + 5'd1)));
      end
      case (m_st)
        0: if (in_valid && in_xop == 6'b110010) begin
          m_st  = 1;
          m_cnt = 0;
          m_exp = 128'(in_a) * 128'(in_b) + 128'(in_c);
          m_rd  = in_rd;
        end
        1: if (m_cnt == 31) m_st = 2; else m_cnt++;
        2: if (out_ready) m_st = 0;
        default: m_st = 0;
      endcase
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        chk(1'b0, "watchdog", 128'(cyc), 128'(0));
        finish_run();
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_mode ? ((cyc % 5) == 4) : 1'b1;
    end
  end

  task automatic send(input logic [5:0] op, input logic [4:0] rd,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    @(posedge clk);
    #1;
    in_valid = 1'b1; in_xop = op; in_rd = rd; in_a = a; in_b = b; in_c = c;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_result();
    do @(negedge clk); while (!out_valid);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", 128'(in_ready), 128'(1));
    chk(out_valid === 1'b0, "R1", 128'(out_valid), 128'(0));

    send(6'b110010, 5'd3, 64'd0, 64'd0, 64'd0);
    send(6'b110010, 5'd7, 64'd0, 64'd0, ONES);
    wait_result();
    chk(out_hi == 64'd0 && out_lo == ONES, "R3", {out_hi, out_lo}, {64'd0, ONES});

    send(6'b110010, 5'd9, ONES, ONES, ONES);
    wait_result();
    chk(out_hi == ONES && out_lo == 64'd0, "R9", {out_hi, out_lo}, {ONES, 64'd0});

    send(6'b110010, 5'd31, ONES, ONES, 64'd0);
    wait_result();
    chk(out_rd_hi == 5'd0, "R8", 128'(out_rd_hi), 128'(0));

    send(6'b110010, 5'd1, 64'd1, ONES, ONES);
    send(6'b110010, 5'd2, 64'h8000_0000_0000_0000, 64'd2, 64'd5);

    foreach (NEIGHBOURS[k]) begin
      send(NEIGHBOURS[k], 5'd4, ONES, ONES, ONES);
      repeat (40) @(negedge clk);
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R7", {out_valid, in_ready}, 2'b01);
    end

    for (int i = 0; i < 10; i++) begin
      rng = next_rng(rng);
      in_a = rng;
      rng = next_rng(rng);
      send(6'b110010, 5'(i * 3), in_a, rng, next_rng(rng ^ 64'h5555));
    end

    stall_mode = 1'b1;
    for (int i = 0; i < 8; i++) begin
      rng = next_rng(rng);
      in_a = rng;
      rng = next_rng(rng);
      send(6'b110010, 5'(30 + i), in_a, rng, (i % 2 == 0) ? ONES : rng);
    end
    send(6'b110011, 5'd0, ONES, 64'd1, 64'd1);
    stall_mode = 1'b0;
    repeat (60) @(negedge clk);
    finish_run();
  end

  localparam logic [5:0] NEIGHBOURS [4] = '{6'b110000, 6'b110001, 6'b110011, 6'b000000};
endmodule